// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block takes configuration for a stereo audio playback path over a slow three-wire link: a serial data line, a serial bit clock and a latch strobe. All three lines are brought into the system clock domain through synchronizer chains. Bits are then shifted into a 16-bit word on each rising edge of the serial clock, and a rising edge of the latch line commits the word. The two lowest bits of the word are an address. They pick the left volume register, the right volume register or the control register, and that register receives the upper 14 bits.

The control register is split into its fields: right-justified word length, serial input format, de-emphasis curve, soft mute, soft reset, and the two sample-rate multiplier selects. Several of these fields are merged with board-level pins. The format, mute and rate fields are ORed with their pins. A high de-emphasis pin forces the 44.1 kHz curve. The block outputs the raw register contents and the merged configuration for the datapath to use.

Top module: `cfg_serial_port`

## Requirements
- R1: After hardware reset both volume outputs read 0x3FFF, the control payload reads 0, and every decoded field is 0 while all pins are low.
- R2: Bits are taken MSB first on each rising serial clock. A rising latch edge writes word bits 15:2 into the register chosen by word bits 1:0: 00 left volume, 10 right volume, 01 control.
- R3: A latch edge on a word whose address bits are 11 leaves all three registers unchanged.
- R4: Registers change only after a latch rising edge. The serial clock may toggle freely between writes without altering any register.
- R5: The word length output is word bits 9:8 of the last control write (00 = 24, 01 = 20, 10 = 16 bits).
- R6: The serial format output is word bits 5:4 of the control register ORed with the two format pins.
- R7: The de-emphasis output is word bits 3:2 of the control register (00 none, 01 44.1 kHz, 10 32 kHz, 11 48 kHz) while the de-emphasis pin is low, and 01 while it is high.
- R8: The mute output is control word bit 6 ORed with the mute pin.
- R9: The 4x-rate output is control word bit 10 ORed with its pin, and the 2x-rate output is control word bit 11 ORed with its pin.
- R10: The soft-reset output is control word bit 7. Setting or clearing it leaves both volume registers unchanged.
- R11: A register write appears at the outputs exactly three system clock edges after the latch line rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch strobe, rising edge commits word |
| pin_mode_i | input | 2 | Serial format pins, ORed into format field |
| pin_mute_i | input | 1 | Mute pin |
| pin_rate4_i | input | 1 | 4x-rate select pin |
| pin_rate2_i | input | 1 | 2x-rate select pin |
| pin_deemph_i | input | 1 | Forces the 44.1 kHz de-emphasis curve |
| vol_left_o | output | 14 | Left volume register |
| vol_right_o | output | 14 | Right volume register |
| ctrl_word_o | output | 14 | Raw control register payload |
| word_len_o | output | 2 | Right-justified word length code |
| ser_mode_o | output | 2 | Effective serial format |
| deemph_o | output | 2 | Effective de-emphasis curve |
| mute_o | output | 1 | Effective mute |
| soft_reset_o | output | 1 | Soft reset request |
| rate4x_o | output | 1 | Effective 4x-rate select |
| rate2x_o | output | 1 | Effective 2x-rate select |

## Verification
A serial line level crosses two synchronizer flops and an edge-history flop, so a latch edge driven between clock edges reaches the registers on the third system clock edge after it. The latency check samples on the falling clock edge after the second rising edge to see the old value, and again after the third to see the new one. Every other check holds each serial line level for four system cycles and waits well past that window before sampling. The pin-merged fields are combinational from the registers, so they are sampled one half-cycle after a pin change.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ADDR_VOL_L = 2'b00,
        ADDR_CTRL  = 2'b01,
        ADDR_VOL_R = 2'b10,
        ADDR_NONE  = 2'b11
    } cfg_addr_e;

    // field offsets inside the 14-bit payload (word bit minus 2)
    localparam int FLD_DEEMPH = 0;
    localparam int FLD_MODE   = 2;
    localparam int FLD_MUTE   = 4;
    localparam int FLD_SRST   = 5;
    localparam int FLD_WLEN   = 6;
    localparam int FLD_RATE4  = 8;
    localparam int FLD_RATE2  = 9;
    localparam int FLD_USED   = 10;

    typedef struct packed {
        logic [1:0] word_len;
        logic [1:0] ser_mode;
        logic [1:0] deemph;
        logic       mute;
        logic       soft_rst;
        logic       rate4x;
        logic       rate2x;
    } cfg_fields_t;

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfgp_fields.sv
module cfgp_fields
    import cfgp_pkg::*;
#(
    parameter int PAY_W = 14
) (
    input  logic [PAY_W-1:0] ctl_i,
    input  logic [1:0]       pin_mode_i,
    input  logic             pin_mute_i,
    input  logic             pin_rate4_i,
    input  logic             pin_rate2_i,
    input  logic             pin_deemph_i,
    output cfg_fields_t      eff_o
);
    logic unused_hi;
    assign unused_hi = ^ctl_i[PAY_W-1:FLD_USED];

    always_comb begin
        eff_o.word_len = ctl_i[FLD_WLEN +: 2];
        eff_o.ser_mode = ctl_i[FLD_MODE +: 2] | pin_mode_i;
        eff_o.deemph   = pin_deemph_i ? 2'b01 : ctl_i[FLD_DEEMPH +: 2];
        eff_o.mute     = ctl_i[FLD_MUTE]  | pin_mute_i;
        eff_o.soft_rst = ctl_i[FLD_SRST];
        eff_o.rate4x   = ctl_i[FLD_RATE4] | pin_rate4_i;
        eff_o.rate2x   = ctl_i[FLD_RATE2] | pin_rate2_i;
    end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfgp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_lat_i,
    input  logic [1:0]        pin_mode_i,
    input  logic              pin_mute_i,
    input  logic              pin_rate4_i,
    input  logic              pin_rate2_i,
    input  logic              pin_deemph_i,
    output logic [WORD_W-3:0] vol_left_o,
    output logic [WORD_W-3:0] vol_right_o,
    output logic [WORD_W-3:0] ctrl_word_o,
    output logic [1:0]        word_len_o,
    output logic [1:0]        ser_mode_o,
    output logic [1:0]        deemph_o,
    output logic              mute_o,
    output logic              soft_reset_o,
    output logic              rate4x_o,
    output logic              rate2x_o
);
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam logic [PAY_W-1:0] VOL_RST = {PAY_W{1'b1}};

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [PAY_W-1:0]  vol_l;
        logic [PAY_W-1:0]  vol_r;
        logic [PAY_W-1:0]  ctl;
    } state_t;

    state_t st_d, st_q;

    logic [2:0] sync_lvl, sync_rise;
    logic       clk_rise, lat_rise, dat_lvl;
    logic       unused_sync;

    cfgp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ser_lat_i, ser_dat_i, ser_clk_i}),
        .lvl_o  (sync_lvl),
        .rise_o (sync_rise)
    );

    assign clk_rise    = sync_rise[0];
    assign dat_lvl     = sync_lvl[1];
    assign lat_rise    = sync_rise[2];
    assign unused_sync = ^{sync_lvl[2], sync_lvl[0], sync_rise[1]};

    always_comb begin
        st_d = st_q;
        if (clk_rise) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], dat_lvl};
        end
        if (lat_rise) begin
            case (cfg_addr_e'(st_q.shreg[ADDR_W-1:0]))
                ADDR_VOL_L: st_d.vol_l = st_q.shreg[WORD_W-1:ADDR_W];
                ADDR_VOL_R: st_d.vol_r = st_q.shreg[WORD_W-1:ADDR_W];
                ADDR_CTRL:  st_d.ctl   = st_q.shreg[WORD_W-1:ADDR_W];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.vol_l <= VOL_RST;
            st_q.vol_r <= VOL_RST;
            st_q.ctl   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cfg_fields_t eff;

    cfgp_fields #(.PAY_W(PAY_W)) u_fields (
        .ctl_i       (st_q.ctl),
        .pin_mode_i  (pin_mode_i),
        .pin_mute_i  (pin_mute_i),
        .pin_rate4_i (pin_rate4_i),
        .pin_rate2_i (pin_rate2_i),
        .pin_deemph_i(pin_deemph_i),
        .eff_o       (eff)
    );

    assign vol_left_o   = st_q.vol_l;
    assign vol_right_o  = st_q.vol_r;
    assign ctrl_word_o  = st_q.ctl;
    assign word_len_o   = eff.word_len;
    assign ser_mode_o   = eff.ser_mode;
    assign deemph_o     = eff.deemph;
    assign mute_o       = eff.mute;
    assign soft_reset_o = eff.soft_rst;
    assign rate4x_o     = eff.rate4x;
    assign rate2x_o     = eff.rate2x;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int PAY_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lat_rise,
    input logic [1:0]       pin_mode_i,
    input logic             pin_mute_i,
    input logic             pin_rate4_i,
    input logic             pin_rate2_i,
    input logic             pin_deemph_i,
    input logic [PAY_W-1:0] vol_left_o,
    input logic [PAY_W-1:0] vol_right_o,
    input logic [PAY_W-1:0] ctrl_word_o,
    input logic [1:0]       ser_mode_o,
    input logic [1:0]       deemph_o,
    input logic             mute_o,
    input logic             soft_reset_o,
    input logic             rate4x_o,
    input logic             rate2x_o
);
    assert_left_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_left_o) |-> $past(lat_rise));

    assert_right_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_right_o) |-> $past(lat_rise));

    assert_ctrl_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word_o) |-> $past(lat_rise));

    assert_mode_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode_o & pin_mode_i) == pin_mode_i);

    assert_deemph_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_deemph_i |-> deemph_o == 2'b01);

    assert_mute_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mute_i |-> mute_o);

    assert_rate_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rate4_i |-> rate4x_o) and (pin_rate2_i |-> rate2x_o));

    assert_srst_keeps_vol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(soft_reset_o) |-> ($stable(vol_left_o) && $stable(vol_right_o)));
endmodule

bind cfg_serial_port cfgp_checker #(.PAY_W(PAY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat_rise    (lat_rise),
    .pin_mode_i  (pin_mode_i),
    .pin_mute_i  (pin_mute_i),
    .pin_rate4_i (pin_rate4_i),
    .pin_rate2_i (pin_rate2_i),
    .pin_deemph_i(pin_deemph_i),
    .vol_left_o  (vol_left_o),
    .vol_right_o (vol_right_o),
    .ctrl_word_o (ctrl_word_o),
    .ser_mode_o  (ser_mode_o),
    .deemph_o    (deemph_o),
    .mute_o      (mute_o),
    .soft_reset_o(soft_reset_o),
    .rate4x_o    (rate4x_o),
    .rate2x_o    (rate2x_o)
);

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic [1:0] pin_mode = 2'b00;
    logic pin_mute = 1'b0, pin_r4 = 1'b0, pin_r2 = 1'b0, pin_de = 1'b0;
    logic [13:0] vl, vr, cw;
    logic [1:0]  wl, sm, de;
    logic mu, sr, r4, r2;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cfg_serial_port dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_lat_i(ser_lat),
        .pin_mode_i(pin_mode), .pin_mute_i(pin_mute),
        .pin_rate4_i(pin_r4), .pin_rate2_i(pin_r2), .pin_deemph_i(pin_de),
        .vol_left_o(vl), .vol_right_o(vr), .ctrl_word_o(cw),
        .word_len_o(wl), .ser_mode_o(sm), .deemph_o(de),
        .mute_o(mu), .soft_reset_o(sr), .rate4x_o(r4), .rate2x_o(r2)
    );

    // {word, expected left, expected right, expected control}
    localparam logic [57:0] VEC [8] = '{
        {16'h48D0, 14'h1234, 14'h3FFF, 14'h0000},
        {16'h2AF2, 14'h1234, 14'h0ABC, 14'h0000},
        {16'h012D, 14'h1234, 14'h0ABC, 14'h004B},
        {16'hFFFF, 14'h1234, 14'h0ABC, 14'h004B},
        {16'h0000, 14'h0000, 14'h0ABC, 14'h004B},
        {16'hFFFD, 14'h0000, 14'h0ABC, 14'h3FFF},
        {16'hFFFE, 14'h0000, 14'h3FFF, 14'h3FFF},
        {16'h0001, 14'h0000, 14'h3FFF, 14'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            ser_clk = 1'b0;
            ser_dat = w[i];
            hold(4);
            ser_clk = 1'b1;
            hold(4);
        end
        ser_clk = 1'b0;
        hold(4);
    endtask

    task automatic send_word(input logic [15:0] w);
        shift_word(w);
        ser_lat = 1'b1;
        hold(8);
        ser_lat = 1'b0;
        hold(4);
    endtask

    function automatic logic [9:0] fields_of(input logic [13:0] c);
        return {c[7:6], c[3:2], c[1:0], c[4], c[5], c[8], c[9]};
    endfunction

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        hold(5);
        // R1 reset state
        check("R1 left", {18'd0, vl}, 32'h3FFF);
        check("R1 right", {18'd0, vr}, 32'h3FFF);
        check("R1 ctrl", {18'd0, cw}, 32'h0);
        check("R1 fields", {22'd0, wl, sm, de, mu, sr, r4, r2}, 32'h0);
        rst_n = 1'b1;
        hold(4);

        // R2/R3/R5 table walk
        for (int i = 0; i < 8; i++) begin
            send_word(VEC[i][57:42]);
            hold(4);
            check(i == 3 ? "R3 left" : "R2 left", {18'd0, vl}, {18'd0, VEC[i][41:28]});
            check(i == 3 ? "R3 right" : "R2 right", {18'd0, vr}, {18'd0, VEC[i][27:14]});
            check(i == 3 ? "R3 ctrl" : "R2 ctrl", {18'd0, cw}, {18'd0, VEC[i][13:0]});
            check("R5 decoded fields", {22'd0, wl, sm, de, mu, sr, r4, r2},
                  {22'd0, fields_of(VEC[i][13:0])});
        end

        // R11 latency: left volume 0x0155
        shift_word(16'h0554);
        ser_lat = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 before third edge", {18'd0, vl}, 32'h0000);
        @(posedge clk); @(negedge clk);
        check("R11 at third edge", {18'd0, vl}, 32'h0155);
        hold(6);
        ser_lat = 1'b0;
        hold(4);

        // R4 free-running serial clock without latch
        ser_dat = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ser_clk = 1'b1; hold(4);
            ser_clk = 1'b0; hold(4);
        end
        check("R4 left", {18'd0, vl}, 32'h0155);
        check("R4 right", {18'd0, vr}, 32'h3FFF);
        check("R4 ctrl", {18'd0, cw}, 32'h0000);

        // R10 soft reset with mute bit
        send_word(16'h00C1);
        hold(4);
        check("R10 soft reset set", {31'd0, sr}, 32'h1);
        check("R8 mute bit", {31'd0, mu}, 32'h1);
        check("R10 left kept", {18'd0, vl}, 32'h0155);
        check("R10 right kept", {18'd0, vr}, 32'h3FFF);
        send_word(16'h0001);
        hold(4);
        check("R10 soft reset clear", {31'd0, sr}, 32'h0);
        check("R10 left kept after clear", {18'd0, vl}, 32'h0155);

        // R6-R9 pin merge; control: format 10, de-emphasis 10
        send_word(16'h0029);
        hold(4);
        check("R7 register curve", {30'd0, de}, 32'h2);
        pin_mode = 2'b01; pin_mute = 1'b1; pin_r4 = 1'b1; pin_r2 = 1'b1; pin_de = 1'b1;
        hold(1);
        check("R6 format ORed", {30'd0, sm}, 32'h3);
        check("R7 pin forces 44.1", {30'd0, de}, 32'h1);
        check("R8 mute pin", {31'd0, mu}, 32'h1);
        check("R9 rate pins", {30'd0, r4, r2}, 32'h3);
        pin_de = 1'b0; pin_mode = 2'b00; pin_mute = 1'b0; pin_r4 = 1'b0; pin_r2 = 1'b0;
        hold(1);
        check("R7 pin released", {30'd0, de}, 32'h2);
        check("R6 pins released", {30'd0, sm}, 32'h2);
        check("R9 pins released", {29'd0, mu, r4, r2}, 32'h0);

        // R1 hardware reset mid-run
        rst_n = 1'b0;
        hold(2);
        check("R1 reset again left", {18'd0, vl}, 32'h3FFF);
        check("R1 reset again ctrl", {18'd0, cw}, 32'h0);
        rst_n = 1'b1;
        hold(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule